// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Complementary Tone Output

This block is an up-counting interval timer of parameterized width (8 bits by default). It is clocked from the system clock through a power-of-two prescaler with eight selectable taps. Software reaches it through a four-address register bus.

Writing the count address never touches the running counter. The value goes into a hidden reload register. Reading the same address returns the live count. When the counter advances past its all-ones value, it takes the reload value and raises a sticky interrupt flag. Each such wrap also flips a tone phase. That phase drives a pair of complementary outputs, and each output has its own enable. The resulting square wave has a frequency of tick rate / (2 × (256 − reload)).

Register addresses: 0 holds the count (write goes to the reload value, read returns the live count). 1 is control. 2 holds the tone enables. 3 is status.

Top module: `reload_timer`

## Requirements
- R1: After reset, the count, reload value, control, tone enables and interrupt flag all read 0, and both tone outputs are low.
- R2: While control bit 4 (run) is 0, the counter does not change.
- R3: With run at 1 and control bits 2..0 equal to n, the counter advances once every 2^(n+1) clocks. The prescaler is held cleared while run is 0, so the first advance comes a full 2^(n+1) clocks after run is set.
- R4: A write to address 0 changes only the reload value. A read of address 0 returns the live counter.
- R5: An advance from all-ones loads the counter with the reload value and sets the interrupt flag.
- R6: If a write to address 0 falls in the same clock as a wrap, the counter loads the newly written value.
- R7: The interrupt flag (address 3 bit 0, and the irq pin) stays set until a write to address 3 with bit 0 equal to 0 clears it. Writing 1 there has no effect. A wrap in the same clock as a clear leaves the flag set.
- R8: The tone phase starts at 0 and flips on every wrap. tone_o follows the phase.
- R9: tone_n_o is the inverse of the phase. Address 2 bit 0 enables tone_o and bit 1 enables tone_n_o. A disabled output is held low.
- R10: The control byte reads back from address 1 exactly as written. Address 2 reads the enables in bits 1..0, and address 3 reads the flag in bit 0; all other bits read 0. With rd_en low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational, 0 unless rd_en |
| irq | output | 1 | Sticky interrupt request flag |
| tone_o | output | 1 | Tone output, low when disabled |
| tone_n_o | output | 1 | Complementary tone output, low when disabled |

## Verification
Two events can coincide with a wrap: a software write to the reload register, and a software clear of the interrupt flag. The bench runs a cycle-accurate model of the prescaler and counter. From that model it knows when the next rising edge will produce a wrap, and it places the write or clear on exactly that cycle. It then judges the result by reading back the count and by watching irq. The count must equal the new value, and the flag must still be set. Random traffic adds further unplanned coincidences, and the same model judges every read and every pin.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

   typedef enum logic [1:0] {
      REG_COUNT = 2'd0,
      REG_CTRL  = 2'd1,
      REG_OUTEN = 2'd2,
      REG_STAT  = 2'd3
   } reg_addr_e;

   localparam int CTL_RUN_BIT  = 4;
   localparam int EN_TONE_BIT  = 0;
   localparam int EN_TONEN_BIT = 1;
   localparam int STAT_IRQ_BIT = 0;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
   parameter int STAGES = 8,
   parameter int SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   if (STAGES < 1) begin : g_bad_stages
      $error("tick_divider: STAGES must be at least 1");
   end
   if ((1 << SEL_W) < STAGES) begin : g_bad_sel
      $error("tick_divider: SEL_W too narrow for STAGES");
   end

   logic [STAGES-1:0] pre;
   logic [STAGES-1:0] taps;
   logic              tap_hit;

   for (genvar i = 0; i < STAGES; i++) begin : g_tap
      assign taps[i] = &pre[i:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
      end else if (!run) begin
         pre <= '0;
      end else begin
         pre <= pre + 1'b1;
      end
   end

   always_comb begin
      tap_hit = 1'b0;
      for (int k = 0; k < STAGES; k++) begin
         if (32'(sel) == k) tap_hit = taps[k];
      end
   end

   assign tick = run && tap_hit;

   // R3
   prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre == '0));

   // R3
   first_tick_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> !tick);

endmodule

// File: rtl/count_core.sv
module count_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         pl_we,
   input  logic [W-1:0] pl_wdata,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   if (W < 2) begin : g_bad_w
      $error("count_core: W must be at least 2");
   end

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] preload;
   logic [W-1:0] pl_next;

   assign pl_next = pl_we ? pl_wdata : preload;
   assign wrap    = tick && (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload <= '0;
         cnt     <= '0;
      end else begin
         preload <= pl_next;
         if (tick) begin
            cnt <= wrap ? pl_next : cnt + 1'b1;
         end
      end
   end

   // R2
   count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

   // R5
   reload_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !pl_we) |=> (cnt == $past(preload)));

   // R6
   reload_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && pl_we) |=> (cnt == $past(pl_wdata)));

endmodule

// File: rtl/tone_out.sv
module tone_out #(
   parameter bit HAS_TONE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic en_a,
   input  logic en_b,
   output logic out_a,
   output logic out_b
);

   if (HAS_TONE) begin : g_tone
      logic phase;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase <= 1'b0;
         end else if (wrap) begin
            phase <= ~phase;
         end
      end

      assign out_a = en_a & phase;
      assign out_b = en_b & ~phase;

      // R8
      phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wrap |=> (phase != $past(phase)));

      // R8
      phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wrap |=> $stable(phase));

      // R9
      pair_opposed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_a && en_b) |-> (out_a != out_b));
   end else begin : g_no_tone
      assign out_a = 1'b0;
      assign out_b = 1'b0;
   end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import reload_timer_pkg::*;
#(
   parameter int W        = 8,
   parameter int STAGES   = 8,
   parameter int SEL_W    = 3,
   parameter bit HAS_TONE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   addr,
   input  logic         wr_en,
   input  logic         rd_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         irq,
   output logic         tone_o,
   output logic         tone_n_o
);

   if (W < 8) begin : g_bad_w
      $error("reload_timer: W must be at least 8");
   end
   if (SEL_W > CTL_RUN_BIT) begin : g_bad_sel
      $error("reload_timer: select field overlaps run bit");
   end

   logic [W-1:0]     ctl;
   logic [1:0]       ten;
   logic             flag;
   logic             run;
   logic [SEL_W-1:0] sel;
   logic             tick;
   logic             wrap;
   logic [W-1:0]     cnt;
   logic             wr_count;
   logic             wr_ctrl;
   logic             wr_outen;
   logic             irq_clear;

   assign wr_count  = wr_en && (addr == REG_COUNT);
   assign wr_ctrl   = wr_en && (addr == REG_CTRL);
   assign wr_outen  = wr_en && (addr == REG_OUTEN);
   assign irq_clear = wr_en && (addr == REG_STAT) && !wdata[STAT_IRQ_BIT];

   assign run = ctl[CTL_RUN_BIT];
   assign sel = ctl[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         ten  <= '0;
         flag <= 1'b0;
      end else begin
         if (wr_ctrl)  ctl <= wdata;
         if (wr_outen) ten <= wdata[1:0];
         if (wrap) begin
            flag <= 1'b1;
         end else if (irq_clear) begin
            flag <= 1'b0;
         end
      end
   end

   tick_divider #(.STAGES(STAGES), .SEL_W(SEL_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .sel   (sel),
      .tick  (tick)
   );

   count_core #(.W(W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .pl_we    (wr_count),
      .pl_wdata (wdata),
      .cnt      (cnt),
      .wrap     (wrap)
   );

   tone_out #(.HAS_TONE(HAS_TONE)) u_tone (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap  (wrap),
      .en_a  (ten[EN_TONE_BIT]),
      .en_b  (ten[EN_TONEN_BIT]),
      .out_a (tone_o),
      .out_b (tone_n_o)
   );

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            REG_COUNT: rdata = cnt;
            REG_CTRL:  rdata = ctl;
            REG_OUTEN: rdata[1:0] = ten;
            default:   rdata[STAT_IRQ_BIT] = flag;
         endcase
      end
   end

   assign irq = flag;

   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wrap));

   // R7
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en && (addr == REG_STAT) && !wdata[STAT_IRQ_BIT]));

   // R7
   irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> irq);

   // R2
   stopped_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !wrap);

endmodule

// File: tb/sim_reload_timer.sv
module sim_reload_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, tone_o, tone_n_o;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string cur_tag = "R1";

   // bench model state
   logic [7:0] m_pre, m_cnt, m_pl, m_ctl;
   logic [1:0] m_en;
   logic       m_flag, m_tgl;
   logic       m_tk, m_wp;
   logic [7:0] m_pln;

   always #2 clk = ~clk;

   reload_timer u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr), .rd_en(rd),
      .wdata(wdata), .rdata(rdata), .irq(irq), .tone_o(tone_o), .tone_n_o(tone_n_o)
   );

   function automatic logic m_tick();
      logic [7:0] mask;
      mask = 8'((16'd1 << (32'(m_ctl[2:0]) + 1)) - 16'd1);
      return m_ctl[4] && ((m_pre & mask) == mask);
   endfunction

   function automatic logic wrap_next();
      return m_tick() && (m_cnt == 8'hFF);
   endfunction

   function automatic logic [7:0] exp_rdata(input logic [1:0] a);
      case (a)
         2'd0:    return m_cnt;
         2'd1:    return m_ctl;
         2'd2:    return {6'b0, m_en};
         default: return {7'b0, m_flag};
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre = '0; m_cnt = '0; m_pl = '0; m_ctl = '0;
         m_en = '0; m_flag = 1'b0; m_tgl = 1'b0;
      end else begin
         m_tk  = m_tick();
         m_pln = (wr && addr == 2'd0) ? wdata : m_pl;
         m_wp  = m_tk && (m_cnt == 8'hFF);
         if (m_tk) m_cnt = m_wp ? m_pln : m_cnt + 8'd1;
         m_pl  = m_pln;
         m_pre = m_ctl[4] ? m_pre + 8'd1 : 8'd0;
         if (m_wp) m_flag = 1'b1;
         else if (wr && addr == 2'd3 && !wdata[0]) m_flag = 1'b0;
         if (m_wp) m_tgl = ~m_tgl;
         if (wr && addr == 2'd1) m_ctl = wdata;
         if (wr && addr == 2'd2) m_en = wdata[1:0];
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog R2: actual %0d cycles expected under 150000", cycles);
         summary();
         $finish;
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_pins();
      check("R7", {7'b0, irq}, {7'b0, m_flag});
      check("R8", {7'b0, tone_o}, {7'b0, m_en[0] & m_tgl});
      check("R9", {7'b0, tone_n_o}, {7'b0, m_en[1] & ~m_tgl});
   endtask

   // drive at a falling edge, optionally check a read, advance to next falling edge
   task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
      wr = w; rd = r; addr = a; wdata = d;
      #1;
      if (r) check(cur_tag, rdata, exp_rdata(a));
      else check("R10", rdata, 8'h00);
      @(negedge clk);
      chk_pins();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00);
   endtask

   task automatic rd_reg(input logic [1:0] a);
      cyc(1'b0, 1'b1, a, 8'h00);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      cyc(1'b1, 1'b0, a, d);
   endtask

   task automatic wait_wrap();
      for (int i = 0; i < 3000; i++) begin
         if (wrap_next()) break;
         idle(1);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of all registers and pins
      cur_tag = "R1";
      chk_pins();
      for (int a = 0; a < 4; a++) rd_reg(2'(a));
      check("R1", {6'b0, tone_n_o, tone_o}, 8'h00);

      // R10: readback of control and enables
      cur_tag = "R10";
      wr_reg(2'd1, 8'hC5);
      rd_reg(2'd1);
      wr_reg(2'd2, 8'hFF);
      rd_reg(2'd2);
      rd_reg(2'd3);

      // R4: preload write does not disturb the counter
      cur_tag = "R4";
      wr_reg(2'd0, 8'hF8);
      rd_reg(2'd0);
      check("R4", rdata, 8'h00);

      // R2: stopped counter holds
      cur_tag = "R2";
      idle(20);
      rd_reg(2'd0);

      // R3: running at several taps, reading every cycle
      cur_tag = "R3";
      for (int s = 0; s < 3; s++) begin
         wr_reg(2'd1, 8'h00);
         wr_reg(2'd1, 8'h50 | 8'(s));
         for (int i = 0; i < 24; i++) rd_reg(2'd0);
      end
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd1, 8'h53);
      for (int i = 0; i < 17; i++) rd_reg(2'd0);

      // R5: wrap from FF reloads and raises the flag
      cur_tag = "R5";
      wr_reg(2'd1, 8'h50);
      wr_reg(2'd0, 8'hFC);
      wait_wrap();
      idle(1);
      check("R5", {7'b0, irq}, 8'h01);
      rd_reg(2'd0);
      rd_reg(2'd3);

      // R7: writing 1 does not clear, writing 0 does
      cur_tag = "R7";
      wr_reg(2'd3, 8'h01);
      rd_reg(2'd3);
      check("R7", {7'b0, irq}, 8'h01);
      wr_reg(2'd3, 8'h00);
      rd_reg(2'd3);
      check("R7", {7'b0, irq}, 8'h00);

      // R6: reload write in the wrap cycle uses the new value
      cur_tag = "R6";
      wr_reg(2'd0, 8'h10);
      wait_wrap();
      wr_reg(2'd0, 8'hC3);
      rd_reg(2'd0);
      check("R6", rdata, 8'hC3);

      // R7: clear in the wrap cycle leaves the flag set
      cur_tag = "R7";
      wr_reg(2'd0, 8'hF0);
      wr_reg(2'd3, 8'h00);
      wait_wrap();
      wr_reg(2'd3, 8'h00);
      check("R7", {7'b0, irq}, 8'h01);

      // R8 / R9: tone pair over several wraps with each enable pattern
      cur_tag = "R9";
      for (int e = 0; e < 4; e++) begin
         wr_reg(2'd2, 8'(e));
         for (int k = 0; k < 3; k++) begin
            wait_wrap();
            idle(2);
         end
      end

      // random traffic, R5 and others judged by the model
      cur_tag = "R5";
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 4)       wr_reg(2'd1, 8'h50 | 8'($urandom_range(0, 2)));
         else if (r < 5)  wr_reg(2'd1, 8'h40 | 8'($urandom_range(0, 2)));
         else if (r < 10) wr_reg(2'd0, 8'($urandom_range(224, 255)));
         else if (r < 13) wr_reg(2'd2, 8'($urandom_range(0, 3)));
         else if (r < 17) wr_reg(2'd3, 8'($urandom_range(0, 1)));
         else if (r < 45) rd_reg(2'($urandom_range(0, 3)));
         else             idle(1);
      end

      summary();
      $finish;
   end

endmodule